// File: doc/BRIEF.md
# Ordered Store Drain Buffer with Atomic Support

This block sits between a processor core and its data cache. It keeps the core's writes in a ring and releases them to the cache one at a time, oldest first, so every other agent sees them in program order. Plain stores are acknowledged to the core at once. An atomic read-modify-write is acknowledged only when the cache returns the target line, and that acknowledgement carries the bytes the line held before the write.

The cache gets one request at a time, always for the oldest entry. Each response carries a whole line. The block writes the entry's bytes into that line and presents the merged line on a write-back port. It then retires the entry and offers the next one on the following cycle. A store that arrives while older entries wait also produces a prefetch hint for its address. An age monitor raises a sticky stall flag if the oldest entry waits too long.

Top module: `store_buffer_tso`

## Requirements
- R1: The ring holds DEPTH (default 128) entries. `in_ready` is high exactly when fewer than DEPTH entries are held and no atomic is waiting. Entries leave in the order they came in, including after the ring indices wrap.
- R2: `in_kind` 0 is a plain store and 1 is an atomic. A handshake with kind 2 or 3 stores nothing, pulses `in_bad` in that cycle and produces no completion.
- R3: A plain store raises `cmp_valid` with `cmp_atomic`=0 and its `in_tid` in the same cycle as its handshake. No completion appears in any other cycle unless an atomic retires.
- R4: An atomic gives no completion at its handshake. In the cycle its response arrives, `cmp_valid` and `cmp_atomic` are 1, `cmp_tid` is its thread, and `cmp_rdata` holds the old line bytes at its offset, zero-extended.
- R5: From the cycle after an atomic is accepted until the cycle after it retires, `in_ready` is low. The atomic is the only entry left when it retires.
- R6: `pf_valid` pulses with `pf_addr`=`in_addr` in the handshake cycle of a plain store, but only when the buffer already held at least one entry.
- R7: Only the oldest entry is offered on `cq_*`, and never while a response is still awaited. A request that is not accepted keeps `cq_valid` high and `cq_addr` unchanged.
- R8: A response is valid only while one is awaited, and its line address must match the oldest entry. In that cycle `wb_valid` is 1 and `wb_line` is the returned line with 2^`cq_size` entry bytes written in at byte offset `addr[3:0]`. If entries remain, the next one is offered in the following cycle.
- R9: A response never arrives when the buffer is empty.
- R10: The oldest entry is examined once every THRESH cycles while the buffer is occupied. If it has waited THRESH cycles or more, `dl_err` rises and stays high until reset, and `dl_idx` gives its ring slot. An entry drained in time raises nothing.
- R11: After reset, `in_ready`=1 and `cq_valid`, `cmp_valid`, `wb_valid` and `dl_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Core request valid |
| in_ready | output | 1 | Buffer can take a request |
| in_kind | input | 2 | 0 store, 1 atomic, others illegal |
| in_addr | input | AW | Byte address |
| in_size | input | SZ_W | log2 of byte count |
| in_data | input | DW | Write data, byte 0 in low bits |
| in_pc | input | PCW | Program counter of the instruction |
| in_tid | input | TIDW | Thread id |
| in_bad | output | 1 | Illegal kind consumed |
| cmp_valid | output | 1 | Completion to core |
| cmp_tid | output | TIDW | Thread of the completion |
| cmp_atomic | output | 1 | Completion is for an atomic |
| cmp_rdata | output | DW | Old bytes for an atomic |
| pf_valid | output | 1 | Prefetch hint |
| pf_addr | output | AW | Prefetch address |
| cq_valid | output | 1 | Cache request valid |
| cq_ready | input | 1 | Cache accepts request |
| cq_addr | output | AW | Oldest entry address |
| cq_size | output | SZ_W | Oldest entry size |
| cq_atomic | output | 1 | Oldest entry is atomic |
| cq_data | output | DW | Oldest entry data |
| cq_pc | output | PCW | Oldest entry program counter |
| cq_tid | output | TIDW | Oldest entry thread |
| cr_valid | input | 1 | Cache response valid |
| cr_line_addr | input | AW-OFF_W | Line address of response |
| cr_line | input | LINE_BYTES*8 | Line contents before the write |
| wb_valid | output | 1 | Merged line valid |
| wb_line | output | LINE_BYTES*8 | Line with entry bytes merged |
| dl_err | output | 1 | Sticky stall flag |
| dl_idx | output | PTR_W | Ring slot of stalled entry |

## Verification
The bench fills the ring while the cache stalls. A ready check that is off by one would take a 129th entry and overwrite the oldest one. The bench then drains past the wrap point, where a bad wrap would send the wrong addresses. Atomics go in behind pending stores. A design that acknowledged the atomic early, left inserts unblocked or dropped the old bytes would fail there. Bytes at line edges and unaligned offsets catch merge lanes that are shifted. A held cache request catches a design that moves on before it is accepted. The age monitor is run both ways: an entry drained in time must raise no flag, and a stuck one must raise a flag that stays set after the entry drains.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam logic [1:0] KIND_STORE  = 2'd0;
  localparam logic [1:0] KIND_ATOMIC = 2'd1;

  function automatic logic kind_legal(input logic [1:0] k);
    return (k == KIND_STORE) || (k == KIND_ATOMIC);
  endfunction
endpackage

// File: rtl/sb_ring.sv
module sb_ring #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wr_data,
  input  logic             pop,
  output logic [W-1:0]     rd_data,
  output logic [PTR_W-1:0] head_idx,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d = pop  ? bump(head_q) : head_q;
    tail_d = push ? bump(tail_q) : tail_q;
    cnt_d  = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[tail_q] <= wr_data;
  end

  assign rd_data  = mem[head_q];
  assign head_idx = head_q;
  assign count    = cnt_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/sb_merge.sv
module sb_merge #(
  parameter int LINE_BYTES = 16,
  parameter int DATA_BYTES = 8,
  parameter int SZ_W       = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line_in,
  input  logic [OFF_W-1:0]        off,
  input  logic [SZ_W-1:0]         size,
  input  logic [DATA_BYTES*8-1:0] wdata,
  output logic [LINE_BYTES*8-1:0] line_out,
  output logic [DATA_BYTES*8-1:0] old_bytes
);
  int off_i;
  int nb;
  assign off_i = int'(off);
  assign nb    = 32'd1 << size;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    logic sel;
    assign sel = (b >= off_i) && (b < off_i + nb);
    assign line_out[8*b +: 8] = sel ? wdata[8*(b - off_i) +: 8] : line_in[8*b +: 8];
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_old
    int src;
    assign src = off_i + i;
    assign old_bytes[8*i +: 8] = ((i < nb) && (src < LINE_BYTES)) ? line_in[8*src +: 8] : 8'h00;
  end
endmodule

// File: rtl/sb_watchdog.sv
module sb_watchdog #(
  parameter int THRESH = 1024,
  parameter int TSW    = 32,
  parameter int PTR_W  = 7,
  localparam int TMR_W = (THRESH > 1) ? $clog2(THRESH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             busy,
  input  logic [PTR_W-1:0] head_idx,
  input  logic [TSW-1:0]   head_stamp,
  output logic [TSW-1:0]   now,
  output logic             dl_err,
  output logic [PTR_W-1:0] dl_idx
);
  logic [TSW-1:0]   now_q, now_d, age;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             armed_q, armed_d, err_q, err_d, due;
  logic [PTR_W-1:0] idx_q, idx_d;

  always_comb begin
    now_d   = now_q + 1'b1;
    armed_d = armed_q;
    tmr_d   = tmr_q;
    err_d   = err_q;
    idx_d   = idx_q;
    due     = armed_q && (tmr_q == TMR_W'(THRESH - 1));
    age     = now_q - head_stamp;
    if (!armed_q) begin
      if (push) begin
        armed_d = 1'b1;
        tmr_d   = '0;
      end
    end else if (due) begin
      tmr_d   = '0;
      armed_d = busy || push;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
    if (due && busy && !err_q && (age >= TSW'(THRESH))) begin
      err_d = 1'b1;
      idx_d = head_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q   <= '0;
      tmr_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      now_q   <= now_d;
      tmr_q   <= tmr_d;
      armed_q <= armed_d;
      err_q   <= err_d;
      idx_q   <= idx_d;
    end
  end

  assign now    = now_q;
  assign dl_err = err_q;
  assign dl_idx = idx_q;

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_err_needs_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(busy));
endmodule

// File: rtl/store_buffer_tso.sv
module store_buffer_tso
  import sb_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int AW         = 32,
  parameter int PCW        = 32,
  parameter int TIDW       = 4,
  parameter int DATA_BYTES = 8,
  parameter int LINE_BYTES = 16,
  parameter int TSW        = 32,
  parameter int THRESH     = 1024,
  localparam int DW        = DATA_BYTES * 8,
  localparam int LW        = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SZ_W      = $clog2($clog2(DATA_BYTES) + 1),
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [AW-1:0]     in_addr,
  input  logic [SZ_W-1:0]   in_size,
  input  logic [DW-1:0]     in_data,
  input  logic [PCW-1:0]    in_pc,
  input  logic [TIDW-1:0]   in_tid,
  output logic              in_bad,
  output logic              cmp_valid,
  output logic [TIDW-1:0]   cmp_tid,
  output logic              cmp_atomic,
  output logic [DW-1:0]     cmp_rdata,
  output logic              pf_valid,
  output logic [AW-1:0]     pf_addr,
  output logic              cq_valid,
  input  logic              cq_ready,
  output logic [AW-1:0]     cq_addr,
  output logic [SZ_W-1:0]   cq_size,
  output logic              cq_atomic,
  output logic [DW-1:0]     cq_data,
  output logic [PCW-1:0]    cq_pc,
  output logic [TIDW-1:0]   cq_tid,
  input  logic              cr_valid,
  input  logic [AW-OFF_W-1:0] cr_line_addr,
  input  logic [LW-1:0]     cr_line,
  output logic              wb_valid,
  output logic [LW-1:0]     wb_line,
  output logic              dl_err,
  output logic [PTR_W-1:0]  dl_idx
);
  typedef struct packed {
    logic [TSW-1:0]  stamp;
    logic [TIDW-1:0] tid;
    logic [PCW-1:0]  pc;
    logic [DW-1:0]   data;
    logic            atomic;
    logic [SZ_W-1:0] size;
    logic [AW-1:0]   addr;
  } ent_t;
  localparam int ENT_W = $bits(ent_t);

  ent_t             new_ent, head;
  logic [ENT_W-1:0] head_raw;
  logic [PTR_W-1:0] head_idx;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic [TSW-1:0]   now;
  logic             accept, push, push_st, push_at, pop, retire_at;
  logic             wait_q, wait_d, blk_q, blk_d;
  logic [DW-1:0]    old_bytes;

  assign accept    = in_valid && in_ready;
  assign push      = accept && kind_legal(in_kind);
  assign push_st   = push && (in_kind == KIND_STORE);
  assign push_at   = push && (in_kind == KIND_ATOMIC);
  assign pop       = cr_valid && wait_q;
  assign head      = ent_t'(head_raw);
  assign retire_at = pop && head.atomic;

  always_comb begin
    new_ent        = '0;
    new_ent.stamp  = now;
    new_ent.tid    = in_tid;
    new_ent.pc     = in_pc;
    new_ent.data   = in_data;
    new_ent.atomic = (in_kind == KIND_ATOMIC);
    new_ent.size   = in_size;
    new_ent.addr   = in_addr;
  end

  sb_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(new_ent), .pop(pop),
    .rd_data(head_raw), .head_idx(head_idx), .count(count), .full(full), .empty(empty)
  );

  sb_merge #(.LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES), .SZ_W(SZ_W)) u_merge (
    .line_in(cr_line), .off(head.addr[OFF_W-1:0]), .size(head.size), .wdata(head.data),
    .line_out(wb_line), .old_bytes(old_bytes)
  );

  sb_watchdog #(.THRESH(THRESH), .TSW(TSW), .PTR_W(PTR_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .push(push), .busy(!empty), .head_idx(head_idx),
    .head_stamp(head.stamp), .now(now), .dl_err(dl_err), .dl_idx(dl_idx)
  );

  always_comb begin
    wait_d = wait_q;
    blk_d  = blk_q;
    if (cq_valid && cq_ready) wait_d = 1'b1;
    else if (pop)             wait_d = 1'b0;
    if (push_at)        blk_d = 1'b1;
    else if (retire_at) blk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      blk_q  <= blk_d;
    end
  end

  assign in_ready   = !full && !blk_q;
  assign in_bad     = accept && !kind_legal(in_kind);
  assign cmp_valid  = push_st || retire_at;
  assign cmp_tid    = push_st ? in_tid : head.tid;
  assign cmp_atomic = retire_at;
  assign cmp_rdata  = retire_at ? old_bytes : '0;
  assign pf_valid   = push_st && !empty;
  assign pf_addr    = in_addr;
  assign cq_valid   = !empty && !wait_q;
  assign cq_addr    = head.addr;
  assign cq_size    = head.size;
  assign cq_atomic  = head.atomic;
  assign cq_data    = head.data;
  assign cq_pc      = head.pc;
  assign cq_tid     = head.tid;
  assign wb_valid   = pop;

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_valid && !cq_ready) |=> (cq_valid && $stable(cq_addr)));
  p_rsp_when_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> wait_q);
  p_rsp_line_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cr_line_addr == head.addr[AW-1:OFF_W]));
  p_atomic_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_at |-> (count == CNT_W'(1)));
  p_atomic_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_at |=> !in_ready);
  p_bad_no_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad |-> !cmp_valid);
endmodule

// File: tb/store_buffer_tso_tb.sv
module store_buffer_tso_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 128;
  localparam int THR   = 600;
  localparam int QN    = 1024;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_bad;
  logic [1:0]   in_kind;
  logic [31:0]  in_addr, pf_addr, cq_addr;
  logic [1:0]   in_size, cq_size;
  logic [63:0]  in_data, cmp_rdata, cq_data;
  logic [31:0]  in_pc, cq_pc;
  logic [3:0]   in_tid, cmp_tid, cq_tid;
  logic         cmp_valid, cmp_atomic, pf_valid, cq_valid, cq_ready, cq_atomic;
  logic         cr_valid, wb_valid, dl_err;
  logic [27:0]  cr_line_addr;
  logic [127:0] cr_line, wb_line;
  logic [6:0]   dl_idx;

  always #(CLK_P/2) clk = ~clk;

  store_buffer_tso #(.THRESH(THR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_addr(in_addr), .in_size(in_size), .in_data(in_data), .in_pc(in_pc), .in_tid(in_tid),
    .in_bad(in_bad), .cmp_valid(cmp_valid), .cmp_tid(cmp_tid), .cmp_atomic(cmp_atomic),
    .cmp_rdata(cmp_rdata), .pf_valid(pf_valid), .pf_addr(pf_addr), .cq_valid(cq_valid),
    .cq_ready(cq_ready), .cq_addr(cq_addr), .cq_size(cq_size), .cq_atomic(cq_atomic),
    .cq_data(cq_data), .cq_pc(cq_pc), .cq_tid(cq_tid), .cr_valid(cr_valid),
    .cr_line_addr(cr_line_addr), .cr_line(cr_line), .wb_valid(wb_valid), .wb_line(wb_line),
    .dl_err(dl_err), .dl_idx(dl_idx)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [63:0] data;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 32'h0000_1000, 2'd3, 64'h1122_3344_5566_7788},
    '{2'd0, 32'h0000_1003, 2'd0, 64'h0000_0000_0000_00AB},
    '{2'd0, 32'h0000_2006, 2'd1, 64'h0000_0000_0000_BEEF},
    '{2'd2, 32'h0000_3000, 2'd2, 64'h0000_0000_DEAD_0001},
    '{2'd0, 32'h0000_200C, 2'd2, 64'h0000_0000_CAFE_F00D},
    '{2'd0, 32'h0000_4008, 2'd3, 64'hA1B2_C3D4_E5F6_0718},
    '{2'd3, 32'h0000_3004, 2'd0, 64'h0000_0000_0000_0055},
    '{2'd0, 32'h0000_100F, 2'd0, 64'h0000_0000_0000_005A},
    '{2'd0, 32'h0000_5004, 2'd2, 64'h0000_0000_0102_0304},
    '{2'd1, 32'h0000_6008, 2'd3, 64'h0F0E_0D0C_0B0A_0908},
    '{2'd0, 32'h0000_7000, 2'd1, 64'h0000_0000_0000_7777},
    '{2'd1, 32'h0000_7002, 2'd1, 64'h0000_0000_0000_9999}
  };

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_addr [QN];
  logic [1:0]  e_size [QN];
  logic [63:0] e_data [QN];
  logic        e_atom [QN];
  logic [3:0]  e_tid  [QN];
  int wp, rp, occ;
  bit atom_pend, rdy, outst, prev_stall, want_issue, took;
  int lat, cnt;
  logic [31:0] out_addr, prev_addr;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat_line(input logic [27:0] la);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = (la[7:0] * 8'd7 + 8'(i * 13)) ^ la[15:8];
    return r;
  endfunction

  function automatic logic [127:0] f_merge(input logic [127:0] line, input logic [3:0] off,
                                           input logic [1:0] sz, input logic [63:0] d);
    for (int k = 0; k < (1 << sz); k++)
      if (int'(off) + k < 16) line[8*(int'(off) + k) +: 8] = d[8*k +: 8];
    return line;
  endfunction

  function automatic logic [63:0] f_old(input logic [127:0] line, input logic [3:0] off, input logic [1:0] sz);
    logic [63:0] r = '0;
    for (int k = 0; k < (1 << sz); k++)
      if (int'(off) + k < 16) r[8*k +: 8] = line[8*(int'(off) + k) +: 8];
    return r;
  endfunction

  task automatic tick();
    bit rsp_now, is_legal, got_atom;
    int q;
    rsp_now      = outst && (cnt == 0);
    cr_valid     = rsp_now;
    cr_line_addr = out_addr[31:4];
    cr_line      = pat_line(out_addr[31:4]);
    cq_ready     = rdy;
    #1;
    took = 1'b0;
    got_atom = 1'b0;
    chk(in_ready == ((occ < DEPTH) && !atom_pend), "R1 ready", in_ready, (occ < DEPTH) && !atom_pend);
    if (prev_stall) chk(cq_valid && (cq_addr == prev_addr), "R7 hold", cq_addr, prev_addr);
    if (want_issue) chk(cq_valid, "R8 next issue", cq_valid, 1);
    if (cq_valid) begin
      q = rp % QN;
      chk((occ > 0) && (cq_addr == e_addr[q]) && !outst, "R7 head", cq_addr, e_addr[q]);
    end
    want_issue = 1'b0;
    if (wb_valid) begin
      q = rp % QN;
      chk(rsp_now && (occ > 0), "R9 resp", wb_valid, rsp_now);
      chk(wb_line == f_merge(pat_line(e_addr[q][31:4]), e_addr[q][3:0], e_size[q], e_data[q]),
          "R8 merge", wb_line, f_merge(pat_line(e_addr[q][31:4]), e_addr[q][3:0], e_size[q], e_data[q]));
      if (e_atom[q]) begin
        got_atom = 1'b1;
        chk(cmp_valid && cmp_atomic && (cmp_tid == e_tid[q]), "R4 cmp", {cmp_valid, cmp_atomic, cmp_tid}, {2'b11, e_tid[q]});
        chk(cmp_rdata == f_old(pat_line(e_addr[q][31:4]), e_addr[q][3:0], e_size[q]),
            "R4 rdata", cmp_rdata, f_old(pat_line(e_addr[q][31:4]), e_addr[q][3:0], e_size[q]));
        chk(occ == 1, "R5 alone", occ, 1);
        atom_pend = 1'b0;
      end
      rp++;
      occ--;
      want_issue = (occ > 0);
    end
    if (in_valid && in_ready) begin
      took = 1'b1;
      is_legal = (in_kind == 2'd0) || (in_kind == 2'd1);
      if (!is_legal) begin
        chk(in_bad && !cmp_valid, "R2 illegal", {in_bad, cmp_valid}, 2'b10);
      end else begin
        chk(!in_bad, "R2 legal", in_bad, 0);
        if (in_kind == 2'd0) begin
          chk(cmp_valid && !cmp_atomic && (cmp_tid == in_tid), "R3 store cmp", {cmp_valid, cmp_atomic, cmp_tid}, {2'b10, in_tid});
        end else begin
          chk(!cmp_valid, "R4 deferred", cmp_valid, 0);
          atom_pend = 1'b1;
        end
        chk(pf_valid == ((in_kind == 2'd0) && (occ + (wb_valid ? 1 : 0) > 0)), "R6 prefetch", pf_valid,
            (in_kind == 2'd0) && (occ + (wb_valid ? 1 : 0) > 0));
        if (pf_valid) chk(pf_addr == in_addr, "R6 pf addr", pf_addr, in_addr);
        q = wp % QN;
        e_addr[q] = in_addr; e_size[q] = in_size; e_data[q] = in_data;
        e_atom[q] = (in_kind == 2'd1); e_tid[q] = in_tid;
        wp++;
        occ++;
      end
    end else if (!got_atom) begin
      chk(!cmp_valid && !pf_valid, "R3 no stray cmp", {cmp_valid, pf_valid}, 0);
    end
    if (rsp_now) outst = 1'b0;
    if (cq_valid && cq_ready) begin
      outst = 1'b1; cnt = lat; out_addr = cq_addr;
    end else if (outst && cnt > 0) begin
      cnt--;
    end
    prev_stall = cq_valid && !cq_ready;
    prev_addr  = cq_addr;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s,
                      input logic [63:0] d, input logic [3:0] t);
    in_valid = 1'b1; in_kind = k; in_addr = a; in_size = s; in_data = d;
    in_pc = a ^ 32'h8000_0000; in_tid = t;
    for (int n = 0; n < 3000; n++) begin
      tick();
      if (took) break;
      if (n == 2999) chk(1'b0, "R1 accept timeout", 0, 1);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 5000; n++) begin
      if (occ == 0 && !outst) break;
      tick();
    end
    chk(occ == 0, "R1 drain", occ, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_kind = '0; in_addr = '0; in_size = '0; in_data = '0; in_pc = '0; in_tid = '0;
    cq_ready = 1'b0; cr_valid = 1'b0; cr_line_addr = '0; cr_line = '0;
    wp = 0; rp = 0; occ = 0; atom_pend = 0; outst = 0; prev_stall = 0; want_issue = 0; cnt = 0;
    out_addr = '0; prev_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready && !cq_valid && !cmp_valid && !wb_valid && !dl_err, "R11 reset",
        {in_ready, cq_valid, cmp_valid, wb_valid, dl_err}, 5'b10000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rdy = 1'b1; lat = 2;
    @(negedge clk);
    do_reset();
    @(negedge clk);

    // table of mixed stores, illegal kinds and atomics (R2..R9)
    foreach (VEC[i]) send(VEC[i].kind, VEC[i].addr, VEC[i].size, VEC[i].data, 4'(i));
    drain();
    repeat (3) tick();

    // fill to capacity with the cache stalled, then drain across the wrap (R1, R9)
    rdy = 1'b0; lat = 0;
    for (int i = 0; i < DEPTH; i++)
      send(2'd0, 32'h0001_0000 + 32'(i * 8), 2'd3, {32'(i), 32'hC0DE_0000 + 32'(i)}, 4'(i));
    in_valid = 1'b1; in_kind = 2'd0; in_addr = 32'h0002_0000;
    repeat (3) tick();
    chk(!in_ready, "R1 full", in_ready, 0);
    in_valid = 1'b0;
    rdy = 1'b1;
    drain();
    repeat (3) tick();
    chk(!dl_err, "R10 no false alarm", dl_err, 0);

    // stuck entry raises the sticky stall flag (R10)
    do_reset();
    @(negedge clk);
    rdy = 1'b0;
    send(2'd0, 32'h0003_0004, 2'd2, 64'h1234_5678, 4'd9);
    repeat (THR - 5) tick();
    chk(!dl_err, "R10 early", dl_err, 0);
    repeat (10) tick();
    chk(dl_err && (dl_idx == 7'd0), "R10 raised", {dl_err, dl_idx}, {1'b1, 7'd0});
    rdy = 1'b1;
    drain();
    repeat (3) tick();
    chk(dl_err, "R10 sticky", dl_err, 1);
    do_reset();
    chk(!dl_err, "R11 clears flag", dl_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule